// File: doc/BRIEF.md
# Multi-Master Exclusive Access Monitor

This block watches one shared AHB5 segment on which several masters take turns, and decides whether each exclusive store may complete. An exclusive load leaves a reservation for the issuing master on the word that was read. The reservation stays in place until one of three things happens: another master writes that word, the same master issues any exclusive store, or the same master places a new exclusive load somewhere else.

An exclusive store succeeds only while the issuing master still holds a reservation on the same word. The target must also support exclusive accesses. On success the monitor raises `hexokay` in the completion cycle of the store, which is the data-phase cycle in which `hready` is high. `hexokay` stays low if the slave answers with an error. On failure `hexokay` stays low and `store_block` tells the slave to drop the write for the whole data phase.

Blocked stores change no memory, so they never clear another master's reservation. Successful exclusive stores and all ordinary writes do.

Top module: `excl_monitor`

## Requirements
- R1: A synchronous active-high reset, applied at any time, clears every reservation and drives `hexokay` and `store_block` low.
- R2: When a master performs an exclusive load, followed by an exclusive store to the same 4-byte word (any byte offset inside the word), and no conflicting write occurs in between, the store succeeds. `hexokay` is high and `store_block` is low in the store's data-phase cycle.
- R3: A write by a different master to the reserved word makes the reserving master's next exclusive store fail. This holds for an ordinary write and for a successful exclusive store. A failed store has `hexokay` low and `store_block` high in its data phase.
- R4: The following leave a reservation intact: ordinary writes by the owning master itself, writes by other masters to a different word, and reads of any kind other than an exclusive load.
- R5: An exclusive store fails when its master holds no reservation, or holds one on a different word.
- R6: Every exclusive store clears its own master's reservation, whether it succeeds or fails, so a second store with no new load fails.
- R7: A new exclusive load by a master replaces that master's earlier reservation.
- R8: `hexokay` is high only in a cycle where `hready` is high. While `hready` is low, `store_block` holds its value.
- R9: `hexokay` is never high in a cycle where `hresp` is high (error).
- R10: An exclusive store to a target whose `a_tgt_excl` input is low fails.
- R11: A failed exclusive store does not clear any other master's reservation.
- R12: An address phase is taken only in a cycle where `hready` is high. A request presented while `hready` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Address phase carries a transfer (non-idle) |
| a_addr | input | ADDR_W | Byte address of the transfer |
| a_write | input | 1 | 1 = write, 0 = read |
| a_excl | input | 1 | Transfer is exclusive |
| a_mid | input | ID_W | Number of the issuing master |
| a_tgt_excl | input | 1 | Addressed target supports exclusive access |
| hready | input | 1 | Segment ready; completes the data phase and takes the address phase |
| hresp | input | 1 | Slave response, 1 = error |
| hexokay | output | 1 | Exclusive store succeeded, valid in the completion cycle |
| store_block | output | 1 | Data phase holds a failed exclusive store; slave must not write |

## Verification
The hardest case to reach from the ports is an interleaving in which two masters hold reservations on the same word at the same time. In that case the order in which their stores land decides which master wins, and a failed store by the loser must leave other reservations untouched.

The stimulus builds this directly: two masters load the same word, then they store in turn. A third master stores first without any reservation, and the bench shows that the reservation holder still wins afterwards.

Stores are also stretched with `hready` low, and a request is presented during such wait states. This exercises the window in which a design could wrongly accept an address or let the result drift.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  // outcome carried through the data phase of one transfer
  typedef enum logic [1:0] {
    XS_NONE = 2'd0,
    XS_PASS = 2'd1,
    XS_FAIL = 2'd2
  } xs_result_e;
endpackage

// File: rtl/excl_mon_slot.sv
module excl_mon_slot #(
  parameter int TAG_W = 30,
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [TAG_W-1:0] tag,
  input  logic [ID_W-1:0]  mid,
  input  logic             excl,
  input  logic             write,
  input  logic             commit_write,
  output logic             hit
);
  localparam logic [ID_W-1:0] ME = ID_W'(MY_ID);

  logic             held;
  logic [TAG_W-1:0] word;

  assign hit = held && (word == tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      word <= '0;
    end else if (acc) begin
      if (mid == ME) begin
        if (excl && !write) begin
          held <= 1'b1;
          word <= tag;
        end else if (excl && write) begin
          held <= 1'b0;
        end
      end else if (commit_write && (word == tag)) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/excl_mon_dphase.sv
module excl_mon_dphase
  import excl_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic xstore,
  input  logic pass,
  input  logic hready,
  input  logic hresp,
  output logic hexokay,
  output logic store_block
);
  xs_result_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= XS_NONE;
    end else if (acc) begin
      if (!xstore)   st <= XS_NONE;
      else if (pass) st <= XS_PASS;
      else           st <= XS_FAIL;
    end else if (hready) begin
      st <= XS_NONE;
    end
  end

  assign store_block = (st == XS_FAIL);
  assign hexokay     = (st == XS_PASS) && hready && !hresp;
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int BYTE_LANES  = 4,
  localparam int ID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_valid,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_write,
  input  logic              a_excl,
  input  logic [ID_W-1:0]   a_mid,
  input  logic              a_tgt_excl,
  input  logic              hready,
  input  logic              hresp,
  output logic              hexokay,
  output logic              store_block
);
  localparam int OFS_W = (BYTE_LANES > 1) ? $clog2(BYTE_LANES) : 0;
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0]       tag;
  logic [NUM_MASTERS-1:0] hit_vec;
  logic                   acc;
  logic                   own_hit;
  logic                   pass;
  logic                   commit_write;

  assign tag = a_addr[ADDR_W-1:OFS_W];
  assign acc = a_valid && hready;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (a_mid == ID_W'(i)) own_hit = hit_vec[i];
    end
  end

  assign pass         = own_hit && a_tgt_excl;
  assign commit_write = a_write && (!a_excl || pass);

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_slot
    excl_mon_slot #(
      .TAG_W(TAG_W),
      .ID_W (ID_W),
      .MY_ID(g)
    ) u_slot (
      .clk         (clk),
      .rst         (rst),
      .acc         (acc),
      .tag         (tag),
      .mid         (a_mid),
      .excl        (a_excl),
      .write       (a_write),
      .commit_write(commit_write),
      .hit         (hit_vec[g])
    );
  end

  excl_mon_dphase u_dphase (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .xstore     (a_excl && a_write),
    .pass       (pass),
    .hready     (hready),
    .hresp      (hresp),
    .hexokay    (hexokay),
    .store_block(store_block)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic clk,
  input logic rst,
  input logic a_valid,
  input logic a_write,
  input logic a_excl,
  input logic hready,
  input logic hresp,
  input logic hexokay,
  input logic store_block
);
  a_r9_no_okay_on_error: assert property (@(posedge clk) disable iff (rst)
    hresp |-> !hexokay);

  a_r8_okay_needs_ready: assert property (@(posedge clk) disable iff (rst)
    !hready |-> !hexokay);

  a_r8_block_held: assert property (@(posedge clk) disable iff (rst)
    !hready |=> $stable(store_block));

  // R2/R3: a store is either reported good or blocked, never both
  a_r3_okay_or_block: assert property (@(posedge clk) disable iff (rst)
    !(hexokay && store_block));

  a_r12_block_from_taken_store: assert property (@(posedge clk) disable iff (rst)
    $rose(store_block) |-> $past(a_valid && hready && a_excl && a_write));

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!store_block && !hexokay));
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_valid    (a_valid),
  .a_write    (a_write),
  .a_excl     (a_excl),
  .hready     (hready),
  .hresp      (hresp),
  .hexokay    (hexokay),
  .store_block(store_block)
);

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
  localparam int NM = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_valid = 1'b0;
  logic [31:0] a_addr = '0;
  logic        a_write = 1'b0;
  logic        a_excl = 1'b0;
  logic [1:0]  a_mid = '0;
  logic        a_tgt_excl = 1'b1;
  logic        hready = 1'b1;
  logic        hresp = 1'b0;
  logic        hexokay;
  logic        store_block;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit m_res_v [NM];
  int m_res_w [NM];
  bit m_store_pending = 1'b0;
  bit m_store_good    = 1'b0;

  always #5 clk = ~clk;

  excl_monitor u0 (
    .clk(clk), .rst(rst), .a_valid(a_valid), .a_addr(a_addr),
    .a_write(a_write), .a_excl(a_excl), .a_mid(a_mid),
    .a_tgt_excl(a_tgt_excl), .hready(hready), .hresp(hresp),
    .hexokay(hexokay), .store_block(store_block)
  );

  task automatic model_edge();
    int w;
    int m;
    bit ok;
    if (rst) begin
      for (int i = 0; i < NM; i++) m_res_v[i] = 1'b0;
      m_store_pending = 1'b0;
      m_store_good    = 1'b0;
    end else if (a_valid && hready) begin
      w = int'(a_addr >> 2);
      m = int'(a_mid);
      m_store_pending = 1'b0;
      m_store_good    = 1'b0;
      if (a_excl && !a_write) begin
        m_res_v[m] = 1'b1;
        m_res_w[m] = w;
      end else if (a_write) begin
        ok = !a_excl || (m_res_v[m] && m_res_w[m] == w && a_tgt_excl);
        if (a_excl) begin
          m_res_v[m]      = 1'b0;
          m_store_pending = 1'b1;
          m_store_good    = ok;
        end
        if (ok) begin
          for (int i = 0; i < NM; i++)
            if (i != m && m_res_v[i] && m_res_w[i] == w) m_res_v[i] = 1'b0;
        end
      end
    end else if (hready) begin
      m_store_pending = 1'b0;
      m_store_good    = 1'b0;
    end
  endtask

  task automatic step(string tag, bit v, int mid, logic [31:0] addr, bit w,
                      bit x, bit tg, bit rdy, bit rsp, bit r);
    bit e_ok;
    bit e_blk;
    rst = r; a_valid = v; a_mid = 2'(mid); a_addr = addr; a_write = w;
    a_excl = x; a_tgt_excl = tg; hready = rdy; hresp = rsp;
    #3;
    e_ok  = !rst && m_store_pending && m_store_good && hready && !hresp;
    e_blk = m_store_pending && !m_store_good;
    checks++;
    if (hexokay !== e_ok) begin
      fails++;
      $display("FAIL %s hexokay actual=%b expected=%b t=%0t", tag, hexokay, e_ok, $time);
    end
    checks++;
    if (store_block !== e_blk) begin
      fails++;
      $display("FAIL %s store_block actual=%b expected=%b t=%0t", tag, store_block, e_blk, $time);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic ld(string t, int m, logic [31:0] a); step(t, 1, m, a, 0, 1, 1, 1, 0, 0); endtask
  task automatic st(string t, int m, logic [31:0] a); step(t, 1, m, a, 1, 1, 1, 1, 0, 0); endtask
  task automatic wr(string t, int m, logic [31:0] a); step(t, 1, m, a, 1, 0, 1, 1, 0, 0); endtask
  task automatic rd(string t, int m, logic [31:0] a); step(t, 1, m, a, 0, 0, 1, 1, 0, 0); endtask
  task automatic idle(string t); step(t, 0, 0, 32'h0, 0, 0, 1, 1, 0, 0); endtask

  initial begin
    for (int i = 0; i < NM; i++) begin m_res_v[i] = 1'b0; m_res_w[i] = 0; end
    @(posedge clk); @(negedge clk);
    step("R1", 0, 0, 32'h0, 0, 0, 1, 1, 0, 1);
    step("R1", 0, 0, 32'h0, 0, 0, 1, 1, 0, 1);
    // R2 basic pair, byte offset within word
    ld("R2", 0, 32'h100); st("R2", 0, 32'h103); idle("R2");
    // R3 ordinary write by another master; R4 different word kept
    ld("R3", 1, 32'h200); wr("R4", 2, 32'h204); wr("R3", 2, 32'h202);
    st("R3", 1, 32'h200); idle("R3");
    // R4 own writes, foreign other-word writes, reads keep reservation
    ld("R4", 0, 32'h300); wr("R4", 0, 32'h300); wr("R4", 3, 32'h310);
    rd("R4", 2, 32'h300); st("R4", 0, 32'h300); idle("R4");
    // R3 successful exclusive store by another master clears
    ld("R3", 0, 32'h400); ld("R3", 1, 32'h400); st("R3", 1, 32'h400);
    st("R3", 0, 32'h400); idle("R3");
    // R11 failed store by a third master leaves holder intact
    ld("R11", 2, 32'h500); st("R11", 3, 32'h500); st("R11", 2, 32'h500); idle("R11");
    // R6 second store without reload fails
    st("R6", 2, 32'h500); idle("R6");
    // R7 reload replaces reservation
    ld("R7", 0, 32'h600); ld("R7", 0, 32'h700); st("R7", 0, 32'h600);
    ld("R7", 0, 32'h800); st("R7", 0, 32'h800); idle("R7");
    // R5 no reservation / wrong word
    st("R5", 1, 32'h900); ld("R5", 1, 32'h900); st("R5", 1, 32'h904); idle("R5");
    // R8 wait states on a good store, then on a failed store
    ld("R8", 3, 32'hA00); st("R8", 3, 32'hA00);
    step("R8", 0, 0, 32'h0, 0, 0, 1, 0, 0, 0);
    step("R8", 0, 0, 32'h0, 0, 0, 1, 0, 0, 0);
    idle("R8");
    st("R8", 3, 32'hA00);
    step("R8", 0, 0, 32'h0, 0, 0, 1, 0, 0, 0);
    idle("R8");
    // R9 error response on a good store
    ld("R9", 3, 32'hB00); st("R9", 3, 32'hB00);
    step("R9", 0, 0, 32'h0, 0, 0, 1, 1, 1, 0);
    idle("R9");
    // R10 target without exclusive support
    ld("R10", 2, 32'hC00); step("R10", 1, 2, 32'hC00, 1, 1, 0, 1, 0, 0); idle("R10");
    // R12 load offered while hready low is not taken
    st("R12", 0, 32'h0);
    step("R12", 1, 1, 32'hD00, 0, 1, 1, 0, 0, 0);
    idle("R12");
    st("R12", 1, 32'hD00); idle("R12");
    // R1 reset in mid-run drops reservations
    ld("R1", 0, 32'hE00);
    step("R1", 0, 0, 32'h0, 0, 0, 1, 1, 0, 1);
    st("R1", 0, 32'hE00); idle("R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule